// File: doc/BRIEF.md
# Floating-Point Compare Condition Generator

This block compares two numeric operands that may arrive in different formats and returns a 32-bit condition word. Each operand carries a 2-bit format selector that marks it as IEEE single precision, IEEE double precision, a signed 32-bit integer or an unsigned 32-bit integer. Each operand is first converted exactly to double precision. Because the conversion is exact, operands of mixed formats share a single ordered comparison.

The condition word sets one bit for each basic relation of the first operand (s1) to the second (s2). It also has four range-test bits that place s1 against the interval running from zero up to s2. A branch unit can then test a single bit, whether it asks "s1 < s2" or asks whether an index falls inside the range 0 to s2. An unordered comparison, where either input is a NaN, gives a word that carries only the unordered marker.

A caller pulses `cmp_go` with the operands valid. One clock later, the word appears on `cond_word` and `cond_vld` is high.

Top module: `fp_cond_word`

## Requirements
- R1: Format code 0 selects single precision, 1 selects double precision, 2 selects signed 32-bit integer and 3 selects unsigned 32-bit integer. A single-precision or integer operand is taken from bits 31:0 of its bus, and bits 63:32 of that bus have no effect on the result.
- R2: If either operand is a NaN, the condition word is exactly 32'h4000_0000: bit 30 is set and every other bit is clear.
- R3: If neither operand is a NaN, bit 31 is set, bit 30 is clear, and bits 19:0 are zero.
- R4: For an ordered comparison, the relation bits are set as follows: bit 20 when s1 equals s2, bit 21 when they differ, bit 22 when s1 > s2, bit 23 when s1 <= s2, bit 24 when s1 < s2, and bit 25 when s1 >= s2.
- R5: Bit 26 is set when s1 < 0 or when s1 > s2.
- R6: Bit 27 is set when 0 < s1 and s1 < s2.
- R7: Bit 28 is set when 0 <= s1 and s1 <= s2.
- R8: Bit 29 is set when s1 <= 0 or when s1 >= s2.
- R9: Positive zero and negative zero compare as equal. An infinity is ordered beyond every finite value of the same sign, and two infinities of the same sign compare as equal.
- R10: Single-precision values, including subnormals, and 32-bit integers are widened with no rounding. An integer that a single cannot represent exactly therefore still compares as unequal to its nearest single.
- R11: `cond_word` and `cond_vld` are registered. A pulse on `cmp_go` makes `cond_vld` high on the next clock edge, and that edge also loads the new word. While `cmp_go` is low, `cond_vld` is low and `cond_word` holds its last value. Reset clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_go | input | 1 | Operands valid; start a compare |
| opa | input | 64 | First operand s1 |
| opb | input | 64 | Second operand s2 |
| fmt_a | input | 2 | Format of opa (0 single, 1 double, 2 signed int, 3 unsigned int) |
| fmt_b | input | 2 | Format of opb (same encoding) |
| cond_word | output | 32 | Registered condition word |
| cond_vld | output | 1 | High for one cycle when cond_word holds a new result |

## Verification
Values of the same format, below, equal to and above each other, separate the six relation bits. Operands swept across the range 0 to s2 (negative, zero, inside, equal to the bound, above it) separate the four range bits, including the closed edges against the open ones. Mixed pairs expose any rounding in the widening step: an integer against a neighbouring single, an unsigned integer against a signed one with the same bits, and a single subnormal against its double twin. Signed zeros, infinities, NaNs in either position and junk in the unused upper bits cover the special encodings. Idle gaps between compares show that the output register holds its value.

// File: rtl/fcw_pkg.sv
// Package: shared encodings for the compare condition generator.
// Assumes IEEE-754 binary32/binary64 layouts.
package fcw_pkg;
    localparam int DW     = 64;   // operand bus / widened form width
    localparam int RW     = 32;   // condition word width
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;

    typedef enum logic [1:0] {
        FMT_SGL = 2'd0,
        FMT_DBL = 2'd1,
        FMT_S32 = 2'd2,
        FMT_U32 = 2'd3
    } fmt_e;

    // condition word bit positions (decoded by consumers)
    localparam int B_EQ   = 20;
    localparam int B_NE   = 21;
    localparam int B_GT   = 22;
    localparam int B_LE   = 23;
    localparam int B_LT   = 24;
    localparam int B_GE   = 25;
    localparam int B_OUT  = 26;
    localparam int B_IN   = 27;
    localparam int B_INC  = 28;
    localparam int B_OUTC = 29;
    localparam int B_UNO  = 30;
    localparam int B_ORD  = 31;
endpackage

// File: rtl/fcw_widen.sv
// Module: fcw_widen
// Converts one operand of any supported format into an exact binary64 image.
// Assumes single/integer operands sit in bits 31:0; upper bits are ignored.
module fcw_widen
    import fcw_pkg::*;
(
    input  logic [DW-1:0] raw,
    input  logic [1:0]    fmt,
    output logic [DW-1:0] dbl
);
    localparam logic [EXP_W-1:0] SGL_BIAS_ADJ = EXP_W'(1023 - 127);
    localparam logic [EXP_W-1:0] SUB_BASE     = EXP_W'(1023 - 149);
    localparam logic [EXP_W-1:0] INT_BASE     = EXP_W'(1023);

    // index of the highest set bit of a nonzero 32-bit value
    function automatic logic [4:0] msb_pos(input logic [31:0] v);
        logic [4:0] p;
        p = '0;
        for (int i = 0; i < 32; i++)
            if (v[i]) p = i[4:0];
        return p;
    endfunction

    logic        s_sign;
    logic [7:0]  s_exp;
    logic [22:0] s_frac;
    logic [31:0] mag;
    logic        i_sign;
    logic [4:0]  pos;
    logic [DW-1:0] shifted;

    assign s_sign = raw[31];
    assign s_exp  = raw[30:23];
    assign s_frac = raw[22:0];

    // magnitude source for the normalising shifter: subnormal fraction or integer
    always_comb begin
        i_sign = 1'b0;
        mag    = '0;
        case (fmt_e'(fmt))
            FMT_SGL: mag = {9'b0, s_frac};
            FMT_S32: begin
                i_sign = raw[31];
                mag    = raw[31] ? (~raw[31:0] + 32'd1) : raw[31:0];
            end
            FMT_U32: mag = raw[31:0];
            default: mag = '0;
        endcase
    end

    assign pos     = msb_pos(mag);
    assign shifted = DW'(mag) << (6'd52 - {1'b0, pos});

    // assemble the binary64 image for the selected format
    always_comb begin
        dbl = '0;
        case (fmt_e'(fmt))
            FMT_DBL: dbl = raw;
            FMT_SGL: begin
                if (s_exp == 8'hFF)
                    dbl = {s_sign, {EXP_W{1'b1}}, s_frac, 29'b0};
                else if (s_exp != 8'h00)
                    dbl = {s_sign, {3'b0, s_exp} + SGL_BIAS_ADJ, s_frac, 29'b0};
                else if (s_frac == '0)
                    dbl = {s_sign, {(DW-1){1'b0}}};
                else
                    dbl = {s_sign, {6'b0, pos} + SUB_BASE, shifted[FRAC_W-1:0]};
            end
            default: begin
                if (mag == '0)
                    dbl = '0;
                else
                    dbl = {i_sign, {6'b0, pos} + INT_BASE, shifted[FRAC_W-1:0]};
            end
        endcase
    end
endmodule

// File: rtl/fcw_order.sv
// Module: fcw_order
// Orders two binary64 values; outputs are meaningful only when neither is NaN.
// Assumes inputs are already widened; treats -0 as +0.
module fcw_order
    import fcw_pkg::*;
(
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic          x_nan,
    output logic          y_nan,
    output logic          lt,
    output logic          eq
);
    // map a binary64 image to an unsigned key whose order matches numeric order
    function automatic logic [DW-1:0] sort_key(input logic [DW-1:0] v);
        logic [DW-1:0] m;
        m = (v[DW-2:0] == '0) ? '0 : v;
        return m[DW-1] ? ~m : (m | {1'b1, {(DW-1){1'b0}}});
    endfunction

    // NaN detection: all-ones exponent with a nonzero fraction
    function automatic logic is_nan(input logic [DW-1:0] v);
        return (v[DW-2:FRAC_W] == '1) && (v[FRAC_W-1:0] != '0);
    endfunction

    logic [DW-1:0] kx, ky;

    // key comparison
    always_comb begin
        kx    = sort_key(x);
        ky    = sort_key(y);
        x_nan = is_nan(x);
        y_nan = is_nan(y);
        lt    = kx < ky;
        eq    = kx == ky;
    end
endmodule

// File: rtl/fcw_encode.sv
// Module: fcw_encode
// Builds the condition word from the s1:s2 and s1:0 orderings.
// Assumes orderings are valid whenever unordered is low.
module fcw_encode
    import fcw_pkg::*;
(
    input  logic          unordered,
    input  logic          lt12,
    input  logic          eq12,
    input  logic          lt10,
    input  logic          eq10,
    output logic [RW-1:0] word
);
    logic gt12, le12, ge12, gt10, le10;

    // derive relation bits and range bits
    always_comb begin
        gt12 = !lt12 && !eq12;
        le12 = lt12 || eq12;
        ge12 = !lt12;
        gt10 = !lt10 && !eq10;
        le10 = lt10 || eq10;
        word = '0;
        if (unordered) begin
            word[B_UNO] = 1'b1;
        end else begin
            word[B_ORD]  = 1'b1;
            word[B_EQ]   = eq12;
            word[B_NE]   = !eq12;
            word[B_GT]   = gt12;
            word[B_LE]   = le12;
            word[B_LT]   = lt12;
            word[B_GE]   = ge12;
            word[B_OUT]  = lt10 || gt12;
            word[B_IN]   = gt10 && lt12;
            word[B_INC]  = !lt10 && le12;
            word[B_OUTC] = le10 || ge12;
        end
    end
endmodule

// File: rtl/fp_cond_word.sv
// Module: fp_cond_word (top)
// Widens two mixed-format operands, compares them and registers a condition word.
// Assumes synchronous active-low reset; one result per cmp_go pulse.
module fp_cond_word
    import fcw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_go,
    input  logic [63:0]   opa,
    input  logic [63:0]   opb,
    input  logic [1:0]    fmt_a,
    input  logic [1:0]    fmt_b,
    output logic [31:0]   cond_word,
    output logic          cond_vld
);
    localparam int NOPS = 2;

    logic [DW-1:0] raw_op [NOPS];
    logic [1:0]    fmt_op [NOPS];
    logic [DW-1:0] wide   [NOPS];

    assign raw_op[0] = opa;
    assign raw_op[1] = opb;
    assign fmt_op[0] = fmt_a;
    assign fmt_op[1] = fmt_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_widen
        fcw_widen u_widen (.raw(raw_op[g]), .fmt(fmt_op[g]), .dbl(wide[g]));
    end

    logic a_nan, b_nan, lt12, eq12;
    logic z_nan_a, z_nan_z, lt10, eq10;
    logic [RW-1:0] word_d;

    fcw_order u_ord12 (.x(wide[0]), .y(wide[1]), .x_nan(a_nan), .y_nan(b_nan),
                       .lt(lt12), .eq(eq12));
    fcw_order u_ord10 (.x(wide[0]), .y('0), .x_nan(z_nan_a), .y_nan(z_nan_z),
                       .lt(lt10), .eq(eq10));

    fcw_encode u_enc (.unordered(a_nan || b_nan), .lt12(lt12), .eq12(eq12),
                      .lt10(lt10), .eq10(eq10), .word(word_d));

    logic unused_ok;
    assign unused_ok = z_nan_a ^ z_nan_z;

    // result register: load on cmp_go, strobe valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_word <= '0;
            cond_vld  <= 1'b0;
        end else begin
            cond_vld <= cmp_go;
            if (cmp_go) cond_word <= word_d;
        end
    end

    // R2
    unordered_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_word[B_UNO] |-> cond_word == 32'h4000_0000);
    // R3
    ordered_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_word[B_ORD] |-> !cond_word[B_UNO] && cond_word[19:0] == '0);
    // R4
    relation_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_word[B_ORD] |-> $countones(cond_word[21:20]) == 1
                          && $countones({cond_word[B_GT], cond_word[B_LE]}) == 1
                          && $countones({cond_word[B_LT], cond_word[B_GE]}) == 1);
    // R5 R7
    closed_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_word[B_ORD] |-> cond_word[B_OUT] != cond_word[B_INC]);
    // R6 R8
    open_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_word[B_ORD] |-> cond_word[B_IN] != cond_word[B_OUTC]);
    // R11
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_go |=> cond_vld);
    // R11
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go && rst_n |=> !cond_vld && $stable(cond_word));
endmodule

// File: tb/fp_cond_word_test.sv
module fp_cond_word_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_go = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [1:0]  fmt_a = '0, fmt_b = '0;
    logic [31:0] cond_word;
    logic        cond_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R11";
    string exp_tag = "R11";
    logic [31:0] exp_word = '0;
    logic        exp_vld = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fp_cond_word uut (.clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .opa(opa), .opb(opb),
                      .fmt_a(fmt_a), .fmt_b(fmt_b), .cond_word(cond_word), .cond_vld(cond_vld));

    // behavioural value of an operand per R1/R10; sets nan for NaN inputs
    function automatic real to_val(input logic [1:0] f, input logic [63:0] v, output bit nan);
        real r;
        int  e;
        nan = 0;
        r = 0.0;
        case (f)
            2'd0: begin
                e = int'(v[30:23]);
                if (e == 255) begin
                    if (v[22:0] != 0) nan = 1;
                    else r = $bitstoreal({v[31], 11'h7FF, 52'b0});
                end else if (e == 0) begin
                    r = real'(longint'(v[22:0])) * (2.0 ** (-149));
                    if (v[31]) r = -r;
                end else begin
                    r = real'(longint'({1'b1, v[22:0]})) * (2.0 ** (e - 150));
                    if (v[31]) r = -r;
                end
            end
            2'd1: begin
                if (v[62:52] == 11'h7FF && v[51:0] != 0) nan = 1;
                else r = $bitstoreal(v);
            end
            2'd2: r = real'(longint'($signed(v[31:0])));
            default: r = real'(longint'({32'b0, v[31:0]}));
        endcase
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic [1:0] fa, input logic [63:0] a,
                                             input logic [1:0] fb, input logic [63:0] b);
        bit na, nb;
        real s1, s2;
        logic [31:0] w;
        s1 = to_val(fa, a, na);
        s2 = to_val(fb, b, nb);
        w = '0;
        if (na || nb) begin
            w[30] = 1;
        end else begin
            w[31] = 1;
            w[20] = s1 == s2;
            w[21] = s1 != s2;
            w[22] = s1 > s2;
            w[23] = s1 <= s2;
            w[24] = s1 < s2;
            w[25] = s1 >= s2;
            w[26] = (s1 < 0.0) || (s1 > s2);
            w[27] = (0.0 < s1) && (s1 < s2);
            w[28] = (0.0 <= s1) && (s1 <= s2);
            w[29] = (s1 <= 0.0) || (s1 >= s2);
        end
        return w;
    endfunction

    // reference model: one register stage per R11
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_word = '0;
            exp_vld  = 1'b0;
            exp_tag  = "R11";
        end else begin
            exp_vld = cmp_go;
            if (cmp_go) begin
                exp_word = ref_word(fmt_a, opa, fmt_b, opb);
                exp_tag  = cur_tag;
            end else begin
                exp_tag = "R11";
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (cond_word !== exp_word || cond_vld !== exp_vld) begin
                errors++;
                $display("FAIL %s: word=%h vld=%b expected word=%h vld=%b",
                         exp_tag, cond_word, cond_vld, exp_word, exp_vld);
            end
        end
    end

    task automatic cmp(input string tag, input logic [1:0] fa, input logic [63:0] a,
                       input logic [1:0] fb, input logic [63:0] b);
        @(posedge clk); #2;
        cur_tag = tag;
        fmt_a = fa; opa = a; fmt_b = fb; opb = b; cmp_go = 1'b1;
        @(posedge clk); #2;
        cmp_go = 1'b0;
        opa = {$urandom, $urandom};
        opb = {$urandom, $urandom};
    endtask

    localparam logic [63:0] D5   = 64'h4014_0000_0000_0000;
    localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] DNINF = 64'hFFF0_0000_0000_0000;

    initial begin
        repeat (3) @(posedge clk);   // reset state checked (R11)
        #2 rst_n = 1'b1;
        // R4 relations, single vs single
        cmp("R4", 2'd0, 64'h3F80_0000, 2'd0, 64'h4000_0000);
        cmp("R4", 2'd0, 64'h4000_0000, 2'd0, 64'h3F80_0000);
        cmp("R4", 2'd0, 64'h4000_0000, 2'd0, 64'h4000_0000);
        cmp("R3", 2'd1, D5, 2'd2, 64'd5);
        // R2 NaN either side
        cmp("R2", 2'd0, 64'h7FC0_0000, 2'd1, D5);
        cmp("R2", 2'd2, 64'd3, 2'd1, DNAN);
        // R5..R8 range sweep, s2 = 5
        cmp("R5", 2'd2, 64'hFFFF_FFFF, 2'd2, 64'd5);
        cmp("R8", 2'd2, 64'd0, 2'd2, 64'd5);
        cmp("R6", 2'd2, 64'd3, 2'd2, 64'd5);
        cmp("R7", 2'd2, 64'd5, 2'd1, D5);
        cmp("R5", 2'd3, 64'd7, 2'd2, 64'd5);
        cmp("R8", 2'd2, 64'd0, 2'd2, 64'hFFFF_FFFD);
        // R9 zeros and infinities
        cmp("R9", 2'd0, 64'h8000_0000, 2'd1, 64'd0);
        cmp("R9", 2'd1, DNINF, 2'd1, D5);
        cmp("R9", 2'd0, 64'h7F80_0000, 2'd1, 64'h7FF0_0000_0000_0000);
        cmp("R9", 2'd0, 64'h7F80_0000, 2'd3, 64'hFFFF_FFFF);
        // R1 upper bits ignored
        cmp("R1", 2'd0, 64'hDEAD_BEEF_3F80_0000, 2'd3, 64'h1234_5678_0000_0001);
        cmp("R1", 2'd2, 64'hFFFF_FFFF_0000_0004, 2'd0, 64'hFFFF_0000_4080_0000);
        // R10 exact widening
        cmp("R10", 2'd2, 64'd16777217, 2'd0, 64'h4B80_0000);
        cmp("R10", 2'd3, 64'hFFFF_FFFF, 2'd2, 64'hFFFF_FFFF);
        cmp("R10", 2'd0, 64'h0000_0001, 2'd1, 64'h36A0_0000_0000_0000);
        cmp("R10", 2'd2, 64'h8000_0000, 2'd0, 64'hCF00_0000);
        // R11 back-to-back then idle hold
        @(posedge clk); #2;
        cur_tag = "R11"; fmt_a = 2'd2; opa = 64'd1; fmt_b = 2'd2; opb = 64'd2; cmp_go = 1'b1;
        @(posedge clk); #2;
        opa = 64'd9;
        @(posedge clk); #2;
        cmp_go = 1'b0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL R11: watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule